// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is a single DMA channel that follows a chain of 128-bit descriptors held in memory. Software loads the descriptor address register and sets the start bit together with the chain mode value. The channel then reads one descriptor at a time. It copies the descriptor's control half and its quadword count into its own registers, and streams the quadwords that belong to the descriptor to an output port. Those quadwords come either from the words directly after the descriptor or from the address that the descriptor carries. The descriptor's kind selects where the next descriptor is fetched from.

The low 64 bits of a descriptor carry the following fields. Bits 15:0 hold the count. Bits 27:26 hold an unused priority field. Bits 30:28 hold the kind. Bit 31 is the interrupt flag. Bits 63:32 hold the pointer, and its top bit selects scratchpad memory. Kinds 5 and 6 form subroutine call and return through a two-entry address stack, so one descriptor list can be reused from several places. The channel reports a clean finish or a bus error to a status block, each as a one-cycle pulse.

The channel makes one read at a time. Each read is held until the memory answers with data or with a bus error. Every address the channel issues has its low four bits at zero. Register access is through a small write/read bus with four word addresses: 0 is control, 1 is memory address, 2 is count and 3 is descriptor address.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, all four registers read zero, and no read request, output beat or status pulse is active.
- R2: Writing the control register (address 0) with bit 8 set starts a chain only when bits 3:2 equal 01. Any other mode value leaves bit 8 reading 0 and issues no read request, while the other written fields are still stored.
- R3: On each descriptor load, bits 31:16 of the descriptor are copied into control bits 31:16, and the descriptor's count (bits 15:0) is copied into the count register. The count register falls by one for each data quadword that is streamed.
- R4: Kind 1 streams the quadwords after the descriptor, and the next descriptor is the quadword right after that data.
- R5: Kind 2 streams the quadwords after the descriptor, and the next descriptor is fetched from the pointer.
- R6: Kinds 3 and 4 stream count quadwords from the pointer, and the next descriptor is the one right after the current descriptor. Kind 0 streams from the pointer and then finishes the chain.
- R7: Kind 5 streams the following data, pushes the address after that data onto the stack and continues at the pointer. Kind 6 streams the following data and then continues at the most recently pushed address. The stack depth reads back in control bits 5:4.
- R8: A kind 6 descriptor with an empty stack finishes the chain normally. A kind 5 descriptor loaded with two entries already on the stack raises the error pulse and moves no data.
- R9: Kind 7 streams the following data and then finishes. A finish gives exactly one completion pulse and clears control bit 8.
- R10: When descriptor bit 31 and the interrupt-enable bit (control bit 7) are both set, the chain finishes after that descriptor's data and address update.
- R11: With descriptor echo enabled (control bit 6), each fetched descriptor appears on the output with the tag marker set, before the data that belongs to it.
- R12: A bus-error response to a descriptor read or a data read produces one error pulse and clears bit 8. No further reads follow. Addresses written by software or taken from a descriptor are forced to 16-byte alignment.
- R13: Register writes made while a chain is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Read byte address, 16-byte aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| mem_berr | input | 1 | Bus-error response to the held request |
| out_valid | output | 1 | Output quadword valid |
| out_tag | output | 1 | Output quadword is an echoed descriptor |
| out_data | output | 128 | Output quadword |
| chain_done | output | 1 | One-cycle pulse on normal finish |
| bus_err | output | 1 | One-cycle pulse on bus error or stack overflow |

## Verification
The states that are hardest to reach from the ports are a full stack that meets a third call, and a return that pops back through two nested levels, one of which has no data. A bus error that arrives in the data phase, rather than in the descriptor phase, is also hard to reach. The bench builds a memory image with nested call descriptors, zero-count descriptors and pointers beyond the mapped range to reach them. A behavioural walker in the bench predicts each output beat, the final register contents and which pulse ends each chain.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    K_REF_END   = 3'd0,
    K_COUNT     = 3'd1,
    K_JUMP      = 3'd2,
    K_REF       = 3'd3,
    K_REF_STALL = 3'd4,
    K_CALL      = 3'd5,
    K_RETURN    = 3'd6,
    K_END       = 3'd7
  } tag_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2,
    ST_STEP  = 2'd3
  } seq_state_e;

  localparam int CTL_DIR    = 0;
  localparam int CTL_MOD_LO = 2;
  localparam int CTL_TTE    = 6;
  localparam int CTL_TIE    = 7;
  localparam int CTL_STR    = 8;

  localparam logic [1:0] MODE_CHAIN = 2'b01;

  localparam logic [1:0] RA_CONTROL = 2'd0;
  localparam logic [1:0] RA_MEMADDR = 2'd1;
  localparam logic [1:0] RA_COUNT   = 2'd2;
  localparam logic [1:0] RA_TAGADDR = 2'd3;

endpackage

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [63:0]   tag_i,
  output logic [CW-1:0] cnt_o,
  output tag_kind_e     kind_o,
  output logic          irq_o,
  output logic [AW-1:0] ptr_o,
  output logic [15:0]   ctl_hi_o,
  output logic          from_ptr_o,
  output logic          skip_tag_o,
  output logic          call_o
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(15);

  always_comb begin
    cnt_o      = tag_i[CW-1:0];
    kind_o     = tag_kind_e'(tag_i[30:28]);
    irq_o      = tag_i[31];
    ptr_o      = tag_i[32 +: AW] & ALIGN_MASK;
    ctl_hi_o   = tag_i[31:16];
    from_ptr_o = (kind_o == K_REF_END) || (kind_o == K_REF) || (kind_o == K_REF_STALL);
    skip_tag_o = (kind_o == K_REF) || (kind_o == K_REF_STALL);
    call_o     = (kind_o == K_CALL);
  end

endmodule

// File: rtl/dma_addr_stack.sv
module dma_addr_stack #(
  parameter int DEPTH = 2,
  parameter int AW    = 32,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  din_i,
  output logic [AW-1:0]  top_o,
  output logic [SPW-1:0] sp_o,
  output logic           full_o,
  output logic           empty_o
);

  logic [AW-1:0]  ent_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_n;

  always_comb begin
    sp_n = sp_q;
    if (clr_i)
      sp_n = '0;
    else if (push_i && !full_o)
      sp_n = sp_q + 1'b1;
    else if (pop_i && !empty_o)
      sp_n = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic wr_en;
    assign wr_en = push_i && !clr_i && (sp_q == SPW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q[gi] <= '0;
      else if (wr_en) ent_q[gi] <= din_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SPW'(i + 1)) top_o = ent_q[i];
  end

  assign sp_o    = sp_q;
  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 128,
  parameter int CW          = 16,
  parameter int STACK_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_berr,
  output logic          out_valid,
  output logic          out_tag,
  output logic [DW-1:0] out_data,
  output logic          chain_done,
  output logic          bus_err
);

  localparam int            SPW        = $clog2(STACK_DEPTH + 1);
  localparam logic [AW-1:0] QW_STEP    = AW'(16);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(15);

  seq_state_e    state_q, state_n;
  logic          str_q, str_n;
  logic          dir_q, dir_n;
  logic [1:0]    mod_q, mod_n;
  logic          tte_q, tte_n;
  logic          tie_q, tie_n;
  logic [15:0]   tagf_q, tagf_n;
  logic [AW-1:0] madr_q, madr_n;
  logic [CW-1:0] qwc_q, qwc_n;
  logic [AW-1:0] tadr_q, tadr_n;
  tag_kind_e     kind_q, kind_n;
  logic          irq_q, irq_n;
  logic [AW-1:0] jump_q, jump_n;
  logic          done_q, done_n;
  logic          berr_q, berr_n;
  logic          halt;

  logic [CW-1:0] dec_cnt;
  tag_kind_e     dec_kind;
  logic          dec_irq;
  logic [AW-1:0] dec_ptr;
  logic [15:0]   dec_hi;
  logic          dec_from_ptr, dec_skip, dec_call;

  logic           stk_clr, stk_push, stk_pop;
  logic [AW-1:0]  stk_top;
  logic [SPW-1:0] stk_sp;
  logic           stk_full, stk_empty;

  dma_tag_decode #(.AW(AW), .CW(CW)) u_decode (
    .tag_i      (mem_rdata[63:0]),
    .cnt_o      (dec_cnt),
    .kind_o     (dec_kind),
    .irq_o      (dec_irq),
    .ptr_o      (dec_ptr),
    .ctl_hi_o   (dec_hi),
    .from_ptr_o (dec_from_ptr),
    .skip_tag_o (dec_skip),
    .call_o     (dec_call)
  );

  dma_addr_stack #(.DEPTH(STACK_DEPTH), .AW(AW), .SPW(SPW)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (stk_clr),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .din_i   (madr_q),
    .top_o   (stk_top),
    .sp_o    (stk_sp),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  // Port-side combinational outputs
  assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_MOVE);
  assign mem_addr   = (state_q == ST_FETCH) ? tadr_q : madr_q;
  assign out_valid  = mem_rvalid && !mem_berr &&
                      ((state_q == ST_MOVE) || ((state_q == ST_FETCH) && tte_q));
  assign out_tag    = (state_q == ST_FETCH);
  assign out_data   = mem_rdata;
  assign chain_done = done_q;
  assign bus_err    = berr_q;

  always_comb begin
    case (reg_addr)
      RA_CONTROL: reg_rdata = {tagf_q, 7'b0, str_q, tie_q, tte_q, 2'(stk_sp),
                               mod_q, 1'b0, dir_q};
      RA_MEMADDR: reg_rdata = 32'(madr_q);
      RA_COUNT:   reg_rdata = 32'(qwc_q);
      default:    reg_rdata = 32'(tadr_q);
    endcase
  end

  // Next-state logic
  always_comb begin
    state_n  = state_q;
    str_n    = str_q;
    dir_n    = dir_q;
    mod_n    = mod_q;
    tte_n    = tte_q;
    tie_n    = tie_q;
    tagf_n   = tagf_q;
    madr_n   = madr_q;
    qwc_n    = qwc_q;
    tadr_n   = tadr_q;
    kind_n   = kind_q;
    irq_n    = irq_q;
    jump_n   = jump_q;
    done_n   = 1'b0;
    berr_n   = 1'b0;
    stk_clr  = 1'b0;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    halt     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (reg_we) begin
          case (reg_addr)
            RA_CONTROL: begin
              dir_n  = reg_wdata[CTL_DIR];
              mod_n  = reg_wdata[CTL_MOD_LO +: 2];
              tte_n  = reg_wdata[CTL_TTE];
              tie_n  = reg_wdata[CTL_TIE];
              tagf_n = reg_wdata[31:16];
              if (reg_wdata[CTL_STR] && (reg_wdata[CTL_MOD_LO +: 2] == MODE_CHAIN)) begin
                str_n   = 1'b1;
                stk_clr = 1'b1;
                state_n = ST_FETCH;
              end
            end
            RA_MEMADDR: madr_n = AW'(reg_wdata) & ALIGN_MASK;
            RA_COUNT:   qwc_n  = CW'(reg_wdata);
            default:    tadr_n = AW'(reg_wdata) & ALIGN_MASK;
          endcase
        end
      end

      ST_FETCH: begin
        if (mem_berr) begin
          berr_n  = 1'b1;
          str_n   = 1'b0;
          state_n = ST_IDLE;
        end else if (mem_rvalid) begin
          tagf_n = dec_hi;
          qwc_n  = dec_cnt;
          kind_n = dec_kind;
          irq_n  = dec_irq;
          jump_n = dec_ptr;
          madr_n = dec_from_ptr ? dec_ptr : (tadr_q + QW_STEP);
          if (dec_skip)
            tadr_n = tadr_q + QW_STEP;
          if (dec_call && stk_full) begin
            berr_n  = 1'b1;
            str_n   = 1'b0;
            state_n = ST_IDLE;
          end else begin
            state_n = (dec_cnt == '0) ? ST_STEP : ST_MOVE;
          end
        end
      end

      ST_MOVE: begin
        if (mem_berr) begin
          berr_n  = 1'b1;
          str_n   = 1'b0;
          state_n = ST_IDLE;
        end else if (mem_rvalid) begin
          madr_n = madr_q + QW_STEP;
          qwc_n  = qwc_q - 1'b1;
          if (qwc_q == CW'(1))
            state_n = ST_STEP;
        end
      end

      ST_STEP: begin
        unique case (kind_q)
          K_REF_END:   halt = 1'b1;
          K_COUNT:     tadr_n = madr_q;
          K_JUMP:      tadr_n = jump_q;
          K_REF,
          K_REF_STALL: ;
          K_CALL: begin
            stk_push = 1'b1;
            tadr_n   = jump_q;
          end
          K_RETURN: begin
            if (stk_empty) begin
              halt = 1'b1;
            end else begin
              stk_pop = 1'b1;
              tadr_n  = stk_top;
            end
          end
          K_END:       halt = 1'b1;
        endcase
        if (irq_q && tie_q)
          halt = 1'b1;
        if (halt) begin
          done_n  = 1'b1;
          str_n   = 1'b0;
          state_n = ST_IDLE;
        end else begin
          state_n = ST_FETCH;
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      str_q   <= 1'b0;
      dir_q   <= 1'b0;
      mod_q   <= 2'b00;
      tte_q   <= 1'b0;
      tie_q   <= 1'b0;
      tagf_q  <= '0;
      madr_q  <= '0;
      qwc_q   <= '0;
      tadr_q  <= '0;
      kind_q  <= K_REF_END;
      irq_q   <= 1'b0;
      jump_q  <= '0;
      done_q  <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      str_q   <= str_n;
      dir_q   <= dir_n;
      mod_q   <= mod_n;
      tte_q   <= tte_n;
      tie_q   <= tie_n;
      tagf_q  <= tagf_n;
      madr_q  <= madr_n;
      qwc_q   <= qwc_n;
      tadr_q  <= tadr_n;
      kind_q  <= kind_n;
      irq_q   <= irq_n;
      jump_q  <= jump_n;
      done_q  <= done_n;
      berr_q  <= berr_n;
    end
  end

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        mem_berr,
  input logic        out_valid,
  input logic        out_tag,
  input logic        chain_done,
  input logic        bus_err,
  input logic        str_q,
  input logic [1:0]  stk_sp,
  input logic [15:0] qwc_q
);

  p_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[3:0] == 4'h0));

  p_req_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> str_q);

  p_berr_halts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_berr) |=> (bus_err && !str_q && !mem_req));

  p_sp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_sp <= 2'd2);

  p_done_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> (!str_q && !mem_req));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chain_done && bus_err));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_tag) |=> (qwc_q == $past(qwc_q) - 16'd1));

  p_out_on_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mem_rvalid);

endmodule

bind dma_chain_seq dma_chain_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .mem_berr   (mem_berr),
  .out_valid  (out_valid),
  .out_tag    (out_tag),
  .chain_done (chain_done),
  .bus_err    (bus_err),
  .str_q      (str_q),
  .stk_sp     (stk_sp),
  .qwc_q      (qwc_q)
);

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb_top;

  logic         clk;
  logic         rst_n;
  logic         reg_we;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid;
  logic [127:0] mem_rdata;
  logic         mem_berr;
  logic         out_valid;
  logic         out_tag;
  logic [127:0] out_data;
  logic         chain_done;
  logic         bus_err;

  dma_chain_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_berr   (mem_berr),
    .out_valid  (out_valid),
    .out_tag    (out_tag),
    .out_data   (out_data),
    .chain_done (chain_done),
    .bus_err    (bus_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests  = 0;
  int fails  = 0;
  int n_done = 0;
  int n_err  = 0;
  string cur_req = "R1";

  logic [127:0] mem [256];
  logic [128:0] exp_q [$];
  bit           exp_err;
  logic [31:0]  exp_tadr, exp_madr, exp_ctrl;
  int           exp_qwc;
  logic [31:0]  cur_madr = 32'h0;
  int           cur_qwc  = 0;

  function automatic bit mapped(input logic [31:0] a);
    return a[30:0] < 31'd4096;
  endfunction

  function automatic logic [127:0] mk_tag(input logic [2:0] id, input logic [15:0] n,
                                          input logic [31:0] a, input bit irq);
    return {32'h7A90_0000, 32'h0000_3C3C, 1'b0, a[30:0], irq, id, 2'b10, 10'h000, n};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [128:0] act, input logic [128:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Memory: one outstanding read, answer one cycle after the request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_berr   <= 1'b0;
      mem_rdata  <= '0;
    end else if (mem_rvalid || mem_berr) begin
      mem_rvalid <= 1'b0;
      mem_berr   <= 1'b0;
    end else if (mem_req) begin
      if (mapped(mem_addr)) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:4]];
      end else begin
        mem_berr <= 1'b1;
      end
    end
  end

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (chain_done) n_done++;
      if (bus_err)    n_err++;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected output beat", {out_tag, out_data}, '0);
        end else begin
          logic [128:0] e;
          e = exp_q.pop_front();
          check({out_tag, out_data} === e, cur_req, "output beat", {out_tag, out_data}, e);
        end
      end
    end
  end

  // Behavioural walker that predicts the whole chain
  function automatic void model_run(input logic [31:0] start, input bit tte, input bit tie);
    logic [31:0]  ta, ma, jump;
    logic [31:0]  stk [2];
    logic [127:0] t;
    logic [15:0]  hi;
    logic [2:0]   id;
    bit           irq, halt;
    int           q, sp;
    ta = start & ~32'hF;
    ma = cur_madr;
    q  = cur_qwc;
    hi = 16'h0;
    sp = 0;
    halt = 0;
    exp_err = 0;
    exp_q.delete();
    for (int g = 0; g < 64 && !halt; g++) begin
      if (!mapped(ta)) begin exp_err = 1; break; end
      t    = mem[ta[11:4]];
      q    = int'(t[15:0]);
      hi   = t[31:16];
      id   = t[30:28];
      irq  = t[31];
      jump = t[63:32] & ~32'hF;
      if (tte) exp_q.push_back({1'b1, t});
      if (id == 0 || id == 3 || id == 4) ma = jump; else ma = ta + 32'd16;
      if (id == 3 || id == 4) ta = ta + 32'd16;
      if (id == 5 && sp == 2) begin exp_err = 1; break; end
      while (q > 0) begin
        if (!mapped(ma)) begin exp_err = 1; break; end
        exp_q.push_back({1'b0, mem[ma[11:4]]});
        ma = ma + 32'd16;
        q--;
      end
      if (exp_err) break;
      case (id)
        3'd0: halt = 1;
        3'd1: ta = ma;
        3'd2: ta = jump;
        3'd5: begin stk[sp] = ma; sp++; ta = jump; end
        3'd6: if (sp == 0) halt = 1; else begin sp--; ta = stk[sp]; end
        3'd7: halt = 1;
        default: ;
      endcase
      if (irq && tie) halt = 1;
    end
    exp_tadr = ta;
    exp_madr = ma;
    exp_qwc  = q;
    exp_ctrl = {hi, 7'b0, 1'b0, tie, tte, 2'(sp), 2'b01, 1'b0, 1'b0};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_chain(input string req, input logic [31:0] start, input bit tte,
                           input bit tie, input bit poke);
    logic [31:0] rv;
    cur_req = req;
    model_run(start, tte, tie);
    reg_write(2'd3, start);
    n_done = 0;
    n_err  = 0;
    reg_write(2'd0, {23'b0, 1'b1, tie, tte, 2'b00, 2'b01, 2'b00});
    if (poke) begin
      // R13: writes during the run must not land
      reg_write(2'd1, 32'h0000_0BC0);
      reg_write(2'd0, 32'h0000_0000);
      reg_write(2'd2, 32'h0000_0077);
    end
    for (int i = 0; i < 3000 && (n_done + n_err) == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_done == (exp_err ? 0 : 1), req, "completion pulses", 129'(n_done), 129'(exp_err ? 0 : 1));
    check(n_err == (exp_err ? 1 : 0), req, "error pulses", 129'(n_err), 129'(exp_err ? 1 : 0));
    check(exp_q.size() == 0, req, "beats left unsent", 129'(exp_q.size()), 129'(0));
    reg_read(2'd3, rv);
    check(rv === exp_tadr, req, "descriptor address", 129'(rv), 129'(exp_tadr));
    reg_read(2'd1, rv);
    check(rv === exp_madr, req, "memory address", 129'(rv), 129'(exp_madr));
    reg_read(2'd2, rv);
    check(rv === 32'(exp_qwc), req, "count", 129'(rv), 129'(exp_qwc));
    reg_read(2'd0, rv);
    check(rv === exp_ctrl, req, "control", 129'(rv), 129'(exp_ctrl));
    cur_madr = exp_madr;
    cur_qwc  = exp_qwc;
    exp_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    bit          req_seen;
    for (int i = 0; i < 256; i++)
      mem[i] = {32'hD47A_0000 | 32'(i), ~32'(i), 32'(i * 3), 32'h1234_0000 + 32'(i)};
    // R4/R5/R9 chain
    mem[8'h00] = mk_tag(3'd1, 16'd2, 32'h0, 1'b0);
    mem[8'h03] = mk_tag(3'd2, 16'd1, 32'h100, 1'b0);
    mem[8'h10] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    // R6 chain
    mem[8'h20] = mk_tag(3'd3, 16'd2, 32'h500, 1'b0);
    mem[8'h21] = mk_tag(3'd4, 16'd1, 32'h600, 1'b0);
    mem[8'h22] = mk_tag(3'd0, 16'd2, 32'h700, 1'b0);
    // R7 nested call/return
    mem[8'h30] = mk_tag(3'd5, 16'd1, 32'h400, 1'b0);
    mem[8'h40] = mk_tag(3'd5, 16'd0, 32'h480, 1'b0);
    mem[8'h48] = mk_tag(3'd6, 16'd1, 32'h0, 1'b0);
    mem[8'h41] = mk_tag(3'd6, 16'd0, 32'h0, 1'b0);
    mem[8'h32] = mk_tag(3'd6, 16'd1, 32'h0, 1'b0);
    // R8 stack overflow
    mem[8'h80] = mk_tag(3'd5, 16'd0, 32'h840, 1'b0);
    mem[8'h84] = mk_tag(3'd5, 16'd0, 32'h880, 1'b0);
    mem[8'h88] = mk_tag(3'd5, 16'd1, 32'h8C0, 1'b0);
    // R10/R11
    mem[8'h90] = mk_tag(3'd1, 16'd1, 32'h0, 1'b1);
    mem[8'h92] = mk_tag(3'd7, 16'd0, 32'h0, 1'b0);
    // R12 bus errors and alignment
    mem[8'hA0] = mk_tag(3'd2, 16'd1, 32'h2000, 1'b0);
    mem[8'hA8] = mk_tag(3'd3, 16'd2, 32'h1FF0, 1'b0);
    mem[8'hB8] = mk_tag(3'd3, 16'd1, 32'hB05, 1'b0);
    mem[8'hB9] = mk_tag(3'd7, 16'd0, 32'h0, 1'b0);

    reg_we    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = 32'h0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rv);
      check(rv === 32'h0, "R1", "register after reset", 129'(rv), 129'(0));
    end
    check({mem_req, out_valid, chain_done, bus_err} === 4'b0, "R1", "idle outputs",
          129'({mem_req, out_valid, chain_done, bus_err}), 129'(0));

    // R2 start with a non-chain mode is refused
    cur_req = "R2";
    reg_write(2'd0, 32'h0000_0108);
    req_seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req) req_seen = 1;
    end
    check(!req_seen, "R2", "request after refused start", 129'(req_seen), 129'(0));
    reg_read(2'd0, rv);
    check(rv === 32'h0000_0008, "R2", "control after refused start", 129'(rv), 129'(32'h8));
    reg_write(2'd0, 32'h0000_0100);
    reg_read(2'd0, rv);
    check(rv === 32'h0000_0000, "R2", "control after mode-0 start", 129'(rv), 129'(0));

    run_chain("R4 R5 R9 R13 R3", 32'h000, 1'b0, 1'b0, 1'b1);
    run_chain("R6", 32'h200, 1'b0, 1'b0, 1'b0);
    run_chain("R7", 32'h300, 1'b0, 1'b0, 1'b0);
    run_chain("R8", 32'h800, 1'b0, 1'b0, 1'b0);
    run_chain("R11", 32'h900, 1'b1, 1'b0, 1'b0);
    run_chain("R10", 32'h900, 1'b0, 1'b1, 1'b0);
    run_chain("R12 fetch", 32'hA00, 1'b0, 1'b0, 1'b0);
    run_chain("R12 data", 32'hA80, 1'b0, 1'b0, 1'b0);
    run_chain("R12 align", 32'hB8F, 1'b1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule